// File: doc/BRIEF.md
# Raw Sample Capture Sequencer with Latency-Offset Readout

This block runs a circular capture buffer for raw ADC samples. While it records, every valid sample goes into an external single-port-per-direction RAM, and the write address wraps at the buffer size. When a trigger accept arrives, recording stops. The block then notes the address of the last sample it wrote and, if sending is enabled, reads back a window of samples from that RAM. The window starts a programmed latency past the last write position and is a programmed number of samples long. All address arithmetic wraps at the buffer size.

After a capture, the block stays frozen. Only an explicit resume command restarts recording, and recording always begins again at address zero. The present state is reported as a five-bit one-hot vector. The RAM is outside the block and has a one-cycle read latency. The read data comes back as an output stream with a valid flag and an end-of-window flag.

Top module: `raw_capture_seq`

## Requirements
- R1: After reset the state vector is 5'b00001 (frozen), and ram_we, ram_re and out_valid are all 0.
- R2: The state vector is one-hot, with bit 0 = frozen, bit 1 = resuming, bit 2 = recording, bit 3 = suspending and bit 4 = sending. Exactly one bit is set at all times.
- R3: A resume command while frozen moves the block to resuming for exactly one cycle, and then to recording. A resume command in any other state has no effect.
- R4: The first valid sample after a resume is written at address 0. Each further valid sample goes to the next address, and address 1023 wraps to 0. A cycle without a valid sample writes nothing.
- R5: A trigger accept while recording moves the block to suspending on the next cycle, and a valid sample in that same cycle is still written. A trigger accept in any other state is ignored.
- R6: The last write address is the address of the most recent sample written since the resume. It is 1023 when no sample was written.
- R7: When leaving suspending, the block goes to sending if send_en is 1, and to frozen with no RAM reads if send_en is 0. lat_ofs, burst_len and send_en are sampled in the suspending cycle.
- R8: In sending, the block issues one read per cycle. The reads cover B addresses, starting at (last + L) mod 1024 and incrementing with wrap; the last address read is (last + L + B - 1) mod 1024. With B = 0 there are no reads. After the window, the block returns to frozen.
- R9: One cycle after each read, out_valid is 1 and out_data carries the RAM read data. out_last is 1 only with the final sample of the window.
- R10: Samples that arrive outside the recording state are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 10 | Raw ADC sample |
| smp_valid | input | 1 | Sample strobe |
| trig_accept | input | 1 | Trigger accept pulse |
| send_en | input | 1 | Send the window after a trigger |
| lat_ofs | input | 10 | Latency offset L |
| burst_len | input | 10 | Window length B |
| resume_cmd | input | 1 | Restart recording command |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | 10 | RAM write address |
| ram_wdata | output | 10 | RAM write data |
| ram_re | output | 1 | RAM read enable |
| ram_raddr | output | 10 | RAM read address |
| ram_rdata | input | 10 | RAM read data, valid one cycle after ram_re |
| out_data | output | 10 | Sent sample |
| out_valid | output | 1 | Sent sample valid |
| out_last | output | 1 | Final sample of the window |
| state_onehot | output | 5 | One-hot state |

## Verification
The assertions assume that ram_rdata holds the contents at ram_raddr exactly one cycle after ram_re, and that resume and trigger pulses are at least one cycle wide. The bench's RAM model has exactly that latency. The bench drives pulses of one cycle on falling edges, and it changes lat_ofs, burst_len and send_en only while the block is frozen. Expected window contents come from a shadow copy of every sample the bench drives while it knows the block is recording.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;
   localparam int ST_N = 5;
   typedef enum logic [2:0] {
      ST_FROZEN     = 3'd0,
      ST_RESUMING   = 3'd1,
      ST_RECORDING  = 3'd2,
      ST_SUSPENDING = 3'd3,
      ST_SENDING    = 3'd4
   } cap_state_e;
endpackage

// File: rtl/cap_seq_fsm.sv
module cap_seq_fsm
   import cap_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       resume,
   input  logic       trig,
   input  logic       send_en,
   input  logic       win_done,
   output cap_state_e state
);
   cap_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_FROZEN:     if (resume) nxt = ST_RESUMING;
         ST_RESUMING:   nxt = ST_RECORDING;
         ST_RECORDING:  if (trig) nxt = ST_SUSPENDING;
         ST_SUSPENDING: nxt = send_en ? ST_SENDING : ST_FROZEN;
         ST_SENDING:    if (win_done) nxt = ST_FROZEN;
         default:       nxt = ST_FROZEN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FROZEN;
      else        state <= nxt;
   end

   // R3: resuming is entered only from frozen and lasts one cycle
   a_r3_resume_from_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RESUMING) |-> ($past(state) == ST_FROZEN));
   a_r3_resume_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RESUMING) |=> (state == ST_RECORDING));
   // R7: suspending always exits to sending or frozen
   a_r7_suspend_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUSPENDING) |=> (state == ST_SENDING || state == ST_FROZEN));
endmodule

// File: rtl/cap_seq_wr_ptr.sv
module cap_seq_wr_ptr #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (clr) ptr <= '0;
      else if (inc) ptr <= ptr + 1'b1;
   end

   // R4: recording restarts at address zero and steps by one with wrap
   a_r4_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr == '0));
   a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));
endmodule

// File: rtl/cap_seq_rd_win.sv
module cap_seq_rd_win #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] wr_next,
   input  logic [ADDR_W-1:0] lat,
   input  logic [ADDR_W-1:0] blen,
   output logic [ADDR_W-1:0] rd_ptr,
   output logic              at_end,
   output logic              final_beat
);
   logic [ADDR_W-1:0] end_ptr;
   logic [ADDR_W-1:0] last_wr;
   logic [ADDR_W-1:0] start_addr;

   // R6: last written address is one behind the next write slot
   assign last_wr    = wr_next - 1'b1;
   assign start_addr = last_wr + lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr  <= '0;
         end_ptr <= '0;
      end else if (load) begin
         rd_ptr  <= start_addr;
         end_ptr <= start_addr + blen;
      end else if (step) begin
         rd_ptr  <= rd_ptr + 1'b1;
      end
   end

   assign at_end     = (rd_ptr == end_ptr);
   assign final_beat = step && (ADDR_W'(rd_ptr + 1'b1) == end_ptr);

   // R8: once the window end is reached the pointer does not move on
   a_r8_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && !load) |=> at_end);
endmodule

// File: rtl/raw_capture_seq.sv
module raw_capture_seq
   import cap_seq_pkg::*;
#(
   parameter int DATA_W  = 10,
   parameter int ADDR_W  = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              smp_valid,
   input  logic              trig_accept,
   input  logic              send_en,
   input  logic [ADDR_W-1:0] lat_ofs,
   input  logic [ADDR_W-1:0] burst_len,
   input  logic              resume_cmd,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_waddr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_raddr,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_last,
   output logic [ST_N-1:0]   state_onehot
);
   if (DATA_W < 1 || ADDR_W < 2) begin : g_bad_params
      $error("raw_capture_seq: DATA_W must be >= 1 and ADDR_W >= 2");
   end

   cap_state_e        state;
   logic [ADDR_W-1:0] wr_ptr;
   logic [ADDR_W-1:0] rd_ptr;
   logic              at_end;
   logic              final_beat;
   logic              in_rec;
   logic              in_send;

   assign in_rec  = (state == ST_RECORDING);
   assign in_send = (state == ST_SENDING);

   cap_seq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .resume   (resume_cmd),
      .trig     (trig_accept),
      .send_en  (send_en),
      .win_done (at_end),
      .state    (state)
   );

   cap_seq_wr_ptr #(.ADDR_W(ADDR_W)) u_wr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state == ST_RESUMING),
      .inc   (ram_we),
      .ptr   (wr_ptr)
   );

   cap_seq_rd_win #(.ADDR_W(ADDR_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (state == ST_SUSPENDING),
      .step       (ram_re),
      .wr_next    (wr_ptr),
      .lat        (lat_ofs),
      .blen       (burst_len),
      .rd_ptr     (rd_ptr),
      .at_end     (at_end),
      .final_beat (final_beat)
   );

   assign ram_we       = in_rec && smp_valid;
   assign ram_waddr    = wr_ptr;
   assign ram_wdata    = smp_data;
   assign ram_re       = in_send && !at_end;
   assign ram_raddr    = rd_ptr;
   assign state_onehot = ST_N'(1) << state;

   if (OUT_REG) begin : g_out_reg
      logic              v1, l1, v2, l2;
      logic [DATA_W-1:0] d2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v1 <= 1'b0; l1 <= 1'b0; v2 <= 1'b0; l2 <= 1'b0; d2 <= '0;
         end else begin
            v1 <= ram_re;
            l1 <= final_beat;
            v2 <= v1;
            l2 <= l1;
            d2 <= v1 ? ram_rdata : '0;
         end
      end
      assign out_valid = v2;
      assign out_last  = l2;
      assign out_data  = d2;
   end else begin : g_out_direct
      logic v1, l1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v1 <= 1'b0; l1 <= 1'b0;
         end else begin
            v1 <= ram_re;
            l1 <= final_beat;
         end
      end
      assign out_valid = v1;
      assign out_last  = l1;
      assign out_data  = v1 ? ram_rdata : '0;
   end

   // R2: exactly one state bit is set
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_onehot) == 1);
   // R10: RAM writes only while recording
   a_r10_write_in_recording: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> state_onehot[2]);
   // R7: RAM reads only while sending
   a_r7_read_in_sending: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> state_onehot[4]);
   // R9: the end flag accompanies a valid sample
   a_r9_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
endmodule

// File: tb/raw_capture_seq_bench.sv
module raw_capture_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] smp_data = '0;
   logic       smp_valid = 1'b0;
   logic       trig_accept = 1'b0;
   logic       send_en = 1'b0;
   logic [9:0] lat_ofs = '0;
   logic [9:0] burst_len = '0;
   logic       resume_cmd = 1'b0;
   logic       ram_we, ram_re, out_valid, out_last;
   logic [9:0] ram_waddr, ram_wdata, ram_raddr, out_data;
   logic [9:0] ram_rdata = '0;
   logic [4:0] state_onehot;

   int nchk = 0;
   int nerr = 0;

   logic [9:0] mem     [1024];
   logic [9:0] exp_mem [1024];

   always #2 clk = ~clk;

   raw_capture_seq u_raw_capture_seq (
      .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
      .trig_accept(trig_accept), .send_en(send_en), .lat_ofs(lat_ofs),
      .burst_len(burst_len), .resume_cmd(resume_cmd), .ram_we(ram_we),
      .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_re(ram_re),
      .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .out_data(out_data),
      .out_valid(out_valid), .out_last(out_last), .state_onehot(state_onehot)
   );

   // RAM model: write and read on the rising edge, one-cycle read latency
   always @(posedge clk) begin
      if (ram_we) mem[ram_waddr] <= ram_wdata;
      if (ram_re) ram_rdata <= mem[ram_raddr];
   end

   // {nsamp[10:0], L[9:0], B[9:0], send}
   localparam logic [31:0] VEC [6] = '{
      {11'd1100, 10'd5,    10'd20,   1'b1},
      {11'd10,   10'd1020, 10'd12,   1'b1},
      {11'd30,   10'd0,    10'd0,    1'b1},
      {11'd40,   10'd3,    10'd15,   1'b0},
      {11'd0,    10'd2,    10'd4,    1'b1},
      {11'd1024, 10'd1023, 10'd1023, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   task automatic run_case(input int nsamp, input int lat, input int blen,
                           input bit snd, input int resume_at, input int seed);
      int wr = 0;
      int last;
      int cnt = 0;
      int bad = 0;
      int last_ok = 1;
      bit finished = 0;
      lat_ofs = 10'(lat); burst_len = 10'(blen); send_en = snd;
      resume_cmd = 1'b1;
      @(negedge clk);
      chk(state_onehot == 5'b00010, "R3", "resuming after resume", state_onehot, 2);
      resume_cmd = 1'b0;
      @(negedge clk);
      chk(state_onehot == 5'b00100, "R3", "recording after one cycle", state_onehot, 4);
      for (int k = 0; k < nsamp; k++) begin
         if (k % 7 == 3) begin
            smp_valid = 1'b0;
            #1;
            if (k == 3) chk(ram_we == 1'b0, "R4", "no write in gap", ram_we, 0);
            @(negedge clk);
         end
         smp_valid = 1'b1;
         smp_data  = 10'((k * 37 + seed * 101 + 5) & 1023);
         trig_accept = (k == nsamp - 1);
         #1;
         if (k == 0)
            chk(ram_we && ram_waddr == 10'd0, "R4", "first write address", ram_waddr, 0);
         if (k == 1024)
            chk(ram_waddr == 10'd0, "R4", "write wraps to 0", ram_waddr, 0);
         exp_mem[wr] = smp_data;
         wr = (wr + 1) & 1023;
         @(negedge clk);
      end
      if (nsamp == 0) begin
         trig_accept = 1'b1;
         @(negedge clk);
      end
      smp_valid = 1'b0; trig_accept = 1'b0;
      chk(state_onehot == 5'b01000, "R5", "suspending after trigger", state_onehot, 8);
      last = (wr - 1) & 1023;
      for (int cyc = 0; cyc < 3000 && !finished; cyc++) begin
         @(negedge clk);
         if (resume_at >= 0 && cyc == resume_at + 1) begin
            resume_cmd = 1'b0;
            chk(state_onehot == 5'b10000, "R3", "resume ignored while sending", state_onehot, 16);
         end
         if (out_valid) begin
            if (out_data !== exp_mem[(last + lat + cnt) & 1023]) bad++;
            if (out_last != (cnt == blen - 1)) last_ok = 0;
            cnt++;
         end
         if (resume_at >= 0 && cyc == resume_at) resume_cmd = 1'b1;
         if (state_onehot == 5'b00001) finished = 1;
      end
      chk(finished, "R8", "returned to frozen", finished, 1);
      chk(cnt == (snd ? blen : 0), snd ? "R8" : "R7", "samples sent", cnt, snd ? blen : 0);
      chk(bad == 0, "R9", "window data mismatches (R6 start)", bad, 0);
      chk(last_ok == 1, "R9", "out_last placement", last_ok, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R8", "watchdog timeout", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) begin
         mem[i] = '0;
         exp_mem[i] = '0;
      end
      repeat (3) @(negedge clk);
      chk(state_onehot == 5'b00001, "R1", "reset state", state_onehot, 1);
      chk(!ram_we && !ram_re && !out_valid, "R1", "reset outputs idle",
          {ram_we, ram_re, out_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(state_onehot == 5'b00001, "R2", "frozen one-hot after reset", state_onehot, 1);
      // trigger and sample while frozen
      smp_valid = 1'b1; smp_data = 10'h3AB; trig_accept = 1'b1;
      #1;
      chk(ram_we == 1'b0, "R10", "no write while frozen", ram_we, 0);
      @(negedge clk);
      smp_valid = 1'b0; trig_accept = 1'b0;
      chk(state_onehot == 5'b00001, "R5", "trigger ignored while frozen", state_onehot, 1);
      // table of capture scenarios
      for (int r = 0; r < 6; r++) begin
         run_case(int'(VEC[r][31:21]), int'(VEC[r][20:11]), int'(VEC[r][10:1]),
                  VEC[r][0], -1, r);
      end
      // resume pulse during a long send
      run_case(50, 7, 200, 1'b1, 30, 9);
      summary();
      $finish;
   end
endmodule